// File: doc/BRIEF.md
# Four-Mode Self-Test Register

This block is a W-bit register that sits between two pieces of combinational logic and changes role under a two-bit mode code. It can act as a plain pipeline register that loads its parallel input. It can act as a serial scan chain, with data entering at a serial input and leaving at the last stage. It can act as a linear feedback shift register that folds its parallel input into the running state. It can also clear itself on a clock edge.

In the compaction mode, a constant all-zero input makes the register a pseudo-random pattern source for the logic downstream. When logic under test drives the parallel input instead, the register condenses that logic's response stream into a signature. A test controller outside the block sequences the modes. That controller is also what compares the signatures. The register holds no expected values.

Stage 0 is the head of the chain and stage W-1 is the tail. The feedback taps are a parameter. By default they follow a maximal-length polynomial for the chosen width, and for W=3 that polynomial is x^3+x^2+1.

Top module: `selftest_reg`

## Requirements
- R1: With md_sel = 2'b11 (normal), every stage i loads par_in[i] on the rising clock edge.
- R2: With md_sel = 2'b00 (scan), stage 0 loads ser_in and stage i (i>0) loads stage i-1 on each edge, so a bit reaches ser_out W edges after it is presented.
- R3: With md_sel = 2'b10 (compaction), stage i (i>0) loads par_in[i] XOR stage i-1, and stage 0 loads par_in[0] XOR the feedback bit.
- R4: The feedback bit is the XOR of the tapped stages. For W=3 the taps are stages 2 and 1 (mask 3'b110, polynomial x^3+x^2+1). In compaction mode this bit replaces ser_in at the head of the chain.
- R5: In compaction mode with par_in held at zero, a non-zero state steps through all 2^W-1 non-zero states before it repeats. For W=3 it returns to its start after exactly 7 edges.
- R6: In compaction mode with par_in at zero, the all-zero state stays all-zero.
- R7: With md_sel = 2'b01 (clear), every stage becomes 0 on the edge, whatever par_in and ser_in are.
- R8: ser_out always equals the last stage, par_out[W-1], in every mode.
- R9: rst is synchronous and active-high, and it clears every stage on the edge whatever the mode. A change of md_sel or of the data inputs has no effect on par_out until the next rising edge.
- R10: Two compaction input streams that differ in a single vector leave different final signatures.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| md_sel | input | 2 | Mode: 11 normal, 00 scan, 10 compaction, 01 clear |
| par_in | input | W | Parallel data from upstream logic |
| ser_in | input | 1 | Serial scan input to stage 0 |
| par_out | output | W | Register contents, stage i on bit i |
| ser_out | output | 1 | Last stage, serial scan output |

## Verification
The bench puts distinct parallel words through the normal mode to show that each bit loads its own input. It shifts an irregular serial pattern through scan, which exposes any reversed or skipped stage at both par_out and ser_out. In compaction mode, a zero input from a scanned-in seed walks the full seven-state cycle, which separates correct taps from wrong ones, and a zero seed confirms the lock-up state. Two response streams that differ in one vector must yield different signatures, and a clear or reset applied from a loaded non-zero state confirms that those paths win over the data inputs.

// File: rtl/str_pkg.sv
package str_pkg;

  typedef enum logic [1:0] {
    MD_SCAN    = 2'b00,
    MD_CLEAR   = 2'b01,
    MD_COMPACT = 2'b10,
    MD_NORMAL  = 2'b11
  } md_e;

  // Tap mask: bit k set means stage k feeds the XOR that drives stage 0.
  // x^n + x^k + ... + 1 maps to bits n-1, k-1, ...
  function automatic logic [31:0] default_taps(input int w);
    logic [31:0] m;
    case (w)
      2:       m = 32'b11;
      3:       m = 32'b110;
      4:       m = 32'b1100;
      5:       m = 32'b10100;
      6:       m = 32'b110000;
      7:       m = 32'b1100000;
      8:       m = 32'b10111000;
      16:      m = 32'b1011010000000000;
      default: m = 32'd3 << (w - 2);
    endcase
    return m;
  endfunction

endpackage

// File: rtl/str_feedback.sv
module str_feedback #(
  parameter int W = 3,
  parameter logic [W-1:0] TAP_MASK = '1
) (
  input  logic [W-1:0] state,
  output logic         fb
);
  assign fb = ^(state & TAP_MASK);
endmodule

// File: rtl/str_cell.sv
module str_cell
  import str_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  md_e  md,
  input  logic d_par,
  input  logic d_chain,
  output logic q
);
  logic nxt;

  always_comb begin
    case (md)
      MD_NORMAL:  nxt = d_par;
      MD_SCAN:    nxt = d_chain;
      MD_COMPACT: nxt = d_par ^ d_chain;
      MD_CLEAR:   nxt = 1'b0;
      default:    nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt;
  end
endmodule

// File: rtl/selftest_reg.sv
module selftest_reg
  import str_pkg::*;
#(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   md_sel,
  input  logic [W-1:0] par_in,
  input  logic         ser_in,
  output logic [W-1:0] par_out,
  output logic         ser_out
);
  localparam logic [31:0]  TAP_FULL = default_taps(W);
  localparam logic [W-1:0] TAP_MASK = TAP_FULL[W-1:0];

  md_e          md;
  logic [W-1:0] q;
  logic [W-1:0] chain;
  logic         fb;

  assign md = md_e'(md_sel);

  str_feedback #(.W(W), .TAP_MASK(TAP_MASK)) u_fb (
    .state (q),
    .fb    (fb)
  );

  // Head of chain: feedback in compaction, serial input otherwise.
  assign chain[0] = (md == MD_COMPACT) ? fb : ser_in;

  genvar i;
  generate
    for (i = 1; i < W; i++) begin : g_link
      assign chain[i] = q[i-1];
    end
    for (i = 0; i < W; i++) begin : g_stage
      str_cell u_cell (
        .clk     (clk),
        .rst     (rst),
        .md      (md),
        .d_par   (par_in[i]),
        .d_chain (chain[i]),
        .q       (q[i])
      );
    end
  endgenerate

  assign par_out = q;
  assign ser_out = q[W-1];
endmodule

// File: rtl/selftest_reg_chk.sv
module selftest_reg_chk #(
  parameter int W = 3
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   md_sel,
  input logic [W-1:0] par_in,
  input logic         ser_in,
  input logic [W-1:0] par_out,
  input logic         ser_out
);
  localparam logic [31:0]  TF  = str_pkg::default_taps(W);
  localparam logic [W-1:0] TAP = TF[W-1:0];

  a_r1_load: assert property (@(posedge clk) disable iff (rst)
    md_sel == 2'b11 |=> par_out == $past(par_in));

  a_r2_scan_shift: assert property (@(posedge clk) disable iff (rst)
    md_sel == 2'b00 |=> par_out == {$past(par_out[W-2:0]), $past(ser_in)});

  // R3, R4: compaction folds input into shifted state with tap feedback
  a_r3_compact: assert property (@(posedge clk) disable iff (rst)
    md_sel == 2'b10 |=> par_out ==
      ($past(par_in) ^ {$past(par_out[W-2:0]), ^($past(par_out) & TAP)}));

  a_r6_zero_lock: assert property (@(posedge clk) disable iff (rst)
    (md_sel == 2'b10 && par_in == '0 && par_out == '0) |=> par_out == '0);

  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    md_sel == 2'b01 |=> par_out == '0);

  a_r8_serout: assert property (@(posedge clk) ser_out == par_out[W-1]);

  a_r9_reset: assert property (@(posedge clk) rst |=> par_out == '0);
endmodule

bind selftest_reg selftest_reg_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .md_sel  (md_sel),
  .par_in  (par_in),
  .ser_in  (ser_in),
  .par_out (par_out),
  .ser_out (ser_out)
);

// File: tb/sim_selftest_reg.sv
`timescale 1ns/1ps
module sim_selftest_reg;
  localparam int W = 3;
  localparam logic [W-1:0] TAPV = 3'b110;   // R4: stages 2 and 1

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   md;
  logic [W-1:0] pi;
  logic         si;
  logic [W-1:0] par_out;
  logic         ser_out;

  int vectors = 0;
  int miscompares = 0;
  logic done = 1'b0;
  logic [W-1:0] expv;

  always #2.5 clk = ~clk;

  selftest_reg #(.W(W)) u0 (
    .clk(clk), .rst(rst), .md_sel(md), .par_in(pi), .ser_in(si),
    .par_out(par_out), .ser_out(ser_out)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Apply one edge of stimulus and check against the bench model.
  task automatic step(input logic r, input logic [1:0] m, input logic [W-1:0] pin,
                      input logic sin, input string tag);
    logic [W-1:0] nx;
    logic fb;
    @(negedge clk);
    rst = r; md = m; pi = pin; si = sin;
    #1 check("R9 hold", par_out, expv);
    fb = ^(expv & TAPV);
    if (r) nx = '0;
    else case (m)
      2'b11: nx = pin;
      2'b00: nx = {expv[W-2:0], sin};
      2'b10: nx = pin ^ {expv[W-2:0], fb};
      default: nx = '0;
    endcase
    @(posedge clk); #1;
    expv = nx;
    check(tag, par_out, expv);
    check("R8", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, expv[W-1]});
  endtask

  task automatic t_reset();
    rst = 1'b1; md = 2'b11; pi = '1; si = 1'b1;
    repeat (2) @(posedge clk);
    #1 expv = '0;
    check("R9 reset", par_out, '0);
  endtask

  task automatic t_load();
    step(0, 2'b11, 3'b101, 0, "R1");
    step(0, 2'b11, 3'b010, 1, "R1");
    step(0, 2'b11, 3'b111, 0, "R1");
    step(1, 2'b11, 3'b110, 1, "R9 sync reset");
  endtask

  task automatic t_scan();
    step(0, 2'b00, 3'b111, 1, "R2");
    step(0, 2'b00, 3'b000, 1, "R2");
    step(0, 2'b00, 3'b111, 0, "R2");
    step(0, 2'b00, 3'b000, 1, "R2");
    step(0, 2'b00, 3'b101, 0, "R2");
  endtask

  task automatic t_clear();
    step(0, 2'b11, 3'b111, 0, "R1");
    step(0, 2'b01, 3'b111, 1, "R7");
    step(0, 2'b01, 3'b101, 1, "R7");
  endtask

  task automatic t_prpg();
    logic [W-1:0] seed;
    logic [(1<<W)-1:0] seen;
    // scan seed 001 into the register
    step(0, 2'b00, '0, 0, "R2");
    step(0, 2'b00, '0, 0, "R2");
    step(0, 2'b00, '0, 1, "R2");
    seed = par_out;
    check("R5 seed", seed, 3'b001);
    seen = '0;
    seen[seed] = 1'b1;
    for (int k = 0; k < 7; k++) begin
      step(0, 2'b10, '0, 1, "R4");
      if (k < 6) begin
        vectors++;
        if (seen[par_out] || par_out == '0) begin
          miscompares++;
          $display("FAIL R5: state %b repeated early at step %0d, expected new state", par_out, k);
        end
        seen[par_out] = 1'b1;
      end
    end
    check("R5 period", par_out, seed);
  endtask

  task automatic t_lock();
    step(0, 2'b01, '0, 0, "R7");
    step(0, 2'b10, '0, 1, "R6");
    step(0, 2'b10, '0, 1, "R6");
    check("R6", par_out, '0);
  endtask

  task automatic run_sig(input logic flip, output logic [W-1:0] sig);
    logic [W-1:0] s [6];
    s[0] = 3'b101; s[1] = 3'b011; s[2] = 3'b110;
    s[3] = 3'b000; s[4] = 3'b111; s[5] = 3'b010;
    if (flip) s[1] = 3'b010;
    step(0, 2'b01, '0, 0, "R7");
    for (int k = 0; k < 6; k++) step(0, 2'b10, s[k], 0, "R3");
    sig = par_out;
  endtask

  task automatic t_sig();
    logic [W-1:0] a, b;
    run_sig(0, a);
    run_sig(1, b);
    vectors++;
    if (a == b) begin
      miscompares++;
      $display("FAIL R10: actual %b equal to %b, expected different", b, a);
    end
  endtask

  initial begin
    t_reset();
    t_load();
    t_scan();
    t_clear();
    t_prpg();
    t_lock();
    t_sig();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule